// File: doc/BRIEF.md
# Two-Wire Slave with Sub-Target Decode

This block is the serial front end of a small trim controller. It watches an oversampled two-wire bus (a clock line and an open-drain data line), waits for a START, and takes in an address byte. The address byte is checked against a fixed 4-bit device type. Its next three bits pick one of two internal targets: a bank of three wiper registers or one 8-bit control register. The last bit picks read or write. The block acknowledges an address only when both the device type and the sub-target code are valid. It then runs a 1-, 2- or 3-byte exchange whose shape depends on the target.

Bit 0 of the control register is a write-enable latch. A wiper write reaches the bank only while that latch is already set. Accepted writes leave the block as a one-cycle strobe with target, index and data. Nothing can stall the bus, so the strobe has no ready input: it is a plain pulse with no back-pressure, and any consumer must take it in the cycle it appears. The wiper bank and the control register are held in the block and are visible on output pins.

Top module: `twowire_trim_slave`

## Requirements
- R1: After reset the data line is released, the control register reads 0x00, and every wiper holds mid-scale, which is 0x80 for 8-bit wipers.
- R2: An address byte whose four upper bits are not 1010 is not acknowledged. The block then drives nothing and changes nothing until the next START or STOP.
- R3: With device type 1010, address bits 3:1 equal to 111 select the wiper bank and 010 select the control register, and the address is acknowledged. Every other code in bits 3:1 is refused. Address bit 0 set means read, and clear means write.
- R4: An acknowledge holds the data line low for the whole high phase of the ninth clock pulse. The line is released shortly after that pulse falls, unless read data follows.
- R5: A control-register write has the form address, then data. The data byte is acknowledged, loaded into the register, and reported by a single-cycle strobe with the register flag set. A third byte is refused.
- R6: In a wiper-bank write, bits 1:0 of the second byte are a pointer, and the upper bits are ignored. Pointer values 0 to 2 are acknowledged and kept for later accesses. Value 3 is refused, and the rest of that transaction has no effect.
- R7: The third byte of a wiper-bank write is acknowledged. It loads the pointed wiper and pulses the strobe only if control bit 0 is set. If that bit is clear, the wiper and the strobe stay unchanged.
- R8: A read sends the control register, or the wiper chosen by the stored pointer, MSB first. A master acknowledge causes the same byte to be sent again. A master not-acknowledge makes the block release the line and stay silent.
- R9: A STOP or a repeated START in the middle of a byte abandons the transaction without any write. A repeated START then begins a new address phase.
- R10: A fourth byte in a wiper-bank write is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | Data line pull-down enable (1 = drive low) |
| wr_stb_o | output | 1 | One-cycle pulse for each accepted register write |
| wr_csr_o | output | 1 | With the strobe: 1 = control register, 0 = wiper |
| wr_idx_o | output | 2 | With the strobe: wiper index |
| wr_data_o | output | 8 | With the strobe: data written |
| wiper_o | output | 24 | Wiper bank, wiper i in bits 8i+7:8i |
| csr_o | output | 8 | Control register, bit 0 = write-enable latch |

## Verification
The bench sends every one of the 256 address bytes and predicts the acknowledge arithmetically from the type and sub-target fields. A loose decode would acknowledge reserved codes or foreign device types, and would then pull the line during the following byte. It sweeps all four pointer values against several wiper values with the latch set and with it clear. A missing latch gate would show up as a changed wiper, and a missing pointer range check would corrupt a wiper through index 3. It also sends over-long transactions, repeated reads with master acknowledge, and STOPs or repeated STARTs in mid-byte. These expose a byte counter that does not saturate, a transmitter that keeps driving after a not-acknowledge, and an abort that still lets a partial byte through as a write.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [2:0] SUB_BANK = 3'b111;
  localparam logic [2:0] SUB_CTRL = 3'b010;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_RACK, S_LOCK
  } tws_state_e;

  typedef enum logic {
    T_BANK, T_CTRL
  } tws_tgt_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_q    = scl_ff[STAGES-1];
  assign sda_q    = sda_ff[STAGES-1];
  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/tws_regs.sv
module tws_regs #(
  parameter int NPOT = 3,
  parameter int WW   = 8,
  localparam int PW  = (NPOT > 1) ? $clog2(NPOT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_ctrl,
  input  logic [PW-1:0]      wr_idx,
  input  logic [7:0]         wr_data,
  input  logic               rd_ctrl,
  input  logic [PW-1:0]      rd_idx,
  output logic [7:0]         rd_data,
  output logic               wel,
  output logic [NPOT*WW-1:0] wipers,
  output logic [7:0]         ctrl
);
  localparam logic [WW-1:0] MID = WW'(1) << (WW - 1);

  logic [WW-1:0] wip [NPOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= 8'h00;
    else if (wr_en && wr_ctrl) ctrl <= wr_data;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NPOT; gi++) begin : g_wiper
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wip[gi] <= MID;
        else if (wr_en && !wr_ctrl && int'(wr_idx) == gi) wip[gi] <= wr_data[WW-1:0];
      end
      assign wipers[gi*WW +: WW] = wip[gi];
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    if (rd_ctrl) rd_data = ctrl;
    else begin
      for (int i = 0; i < NPOT; i++)
        if (int'(rd_idx) == i) rd_data[WW-1:0] = wip[i];
    end
  end

  assign wel = ctrl[0];

  // R7: a wiper write only arrives while the latch is set
  p_wel_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ctrl) |-> wel);
  // R6: a wiper write never carries a reserved index
  p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ctrl) |-> (int'(wr_idx) < NPOT));
endmodule

// File: rtl/twowire_trim_slave.sv
module twowire_trim_slave #(
  parameter int NPOT = 3,
  parameter int WW   = 8,
  parameter int SYNC = 2,
  localparam int PW  = (NPOT > 1) ? $clog2(NPOT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull_o,
  output logic               wr_stb_o,
  output logic               wr_csr_o,
  output logic [PW-1:0]      wr_idx_o,
  output logic [7:0]         wr_data_o,
  output logic [NPOT*WW-1:0] wiper_o,
  output logic [7:0]         csr_o
);
  import tws_pkg::*;

  logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;

  tws_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tws_state_e    st;
  tws_tgt_e      tgt_q;
  logic          rd_q;
  logic [3:0]    bitcnt;
  logic [1:0]    bytenum;
  logic [7:0]    sh;
  logic [7:0]    txsh;
  logic [PW-1:0] ptr_q;
  logic          drv;
  logic          mack;

  logic          ack_ok, wr_req, wr_ctrl, byte_end, wr_go, wel;
  logic [7:0]    rd_data;

  tws_regs #(.NPOT(NPOT), .WW(WW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_go), .wr_ctrl(wr_ctrl), .wr_idx(ptr_q), .wr_data(sh),
    .rd_ctrl(tgt_q == T_CTRL), .rd_idx(ptr_q), .rd_data(rd_data),
    .wel(wel), .wipers(wiper_o), .ctrl(csr_o)
  );

  assign byte_end = (st == S_RX) && scl_fall && (bitcnt == 4'd8);

  // decide acknowledge and write effect for the byte just received
  always_comb begin
    ack_ok  = 1'b0;
    wr_req  = 1'b0;
    wr_ctrl = 1'b0;
    case (bytenum)
      2'd0: ack_ok = (sh[7:4] == DEV_TYPE) &&
                     ((sh[3:1] == SUB_BANK) || (sh[3:1] == SUB_CTRL));
      2'd1: begin
        if (tgt_q == T_CTRL) begin
          ack_ok  = 1'b1;
          wr_req  = 1'b1;
          wr_ctrl = 1'b1;
        end else begin
          ack_ok = (int'(sh[PW-1:0]) < NPOT);
        end
      end
      2'd2: begin
        if (tgt_q == T_BANK) begin
          ack_ok = 1'b1;
          wr_req = wel;
        end
      end
      default: ;
    endcase
  end

  assign wr_go = byte_end && ack_ok && wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tgt_q   <= T_BANK;
      rd_q    <= 1'b0;
      bitcnt  <= '0;
      bytenum <= '0;
      sh      <= '0;
      txsh    <= '0;
      ptr_q   <= '0;
      drv     <= 1'b0;
      mack    <= 1'b0;
    end else if (start_ev) begin
      st      <= S_RX;
      bitcnt  <= '0;
      bytenum <= '0;
      drv     <= 1'b0;
    end else if (stop_ev) begin
      st  <= S_IDLE;
      drv <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            sh     <= {sh[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            if (ack_ok) begin
              drv <= 1'b1;
              st  <= S_ACK;
              if (bytenum == 2'd0) begin
                tgt_q <= (sh[3:1] == SUB_CTRL) ? T_CTRL : T_BANK;
                rd_q  <= sh[0];
              end
              if (bytenum == 2'd1 && tgt_q == T_BANK) ptr_q <= sh[PW-1:0];
            end else begin
              st <= S_LOCK;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (bytenum != 2'd3) bytenum <= bytenum + 2'd1;
            if (rd_q) begin
              st   <= S_TX;
              txsh <= rd_data;
              drv  <= ~rd_data[7];
            end else begin
              st  <= S_RX;
              drv <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              drv  <= 1'b0;
              mack <= 1'b0;
              st   <= S_RACK;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              drv    <= ~txsh[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_q;
          else if (scl_fall) begin
            if (mack) begin
              st     <= S_TX;
              bitcnt <= '0;
              txsh   <= rd_data;
              drv    <= ~rd_data[7];
            end else begin
              st <= S_LOCK;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_o  <= 1'b0;
      wr_csr_o  <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o  <= wr_go;
      wr_csr_o  <= wr_ctrl;
      wr_idx_o  <= ptr_q;
      wr_data_o <= sh;
    end
  end

  assign sda_pull_o = drv;

  // R4: the pull-down only starts while the clock line is low
  p_drive_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv) |-> !scl_q);
  // R2: a refused transaction keeps the line released
  p_lock_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK) |-> !drv);
  // R8: the master's acknowledge slot is never driven by the slave
  p_rack_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK) |-> !drv);
  // R5: every write strobe lasts one cycle
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: tb/twowire_trim_slave_test.sv
module twowire_trim_slave_test;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic wr_stb, wr_csr;
  logic [1:0] wr_idx;
  logic [7:0] wr_data;
  logic [23:0] wiper;
  logic [7:0] csr;
  wire sda_line = sda_m & ~sda_pull;

  int total = 0;
  int bad = 0;
  int nstb = 0;
  logic last_csr;
  logic [1:0] last_idx;
  logic [7:0] last_data;
  logic ack_early, ack_late, ack_after;
  bit done = 0;
  logic [7:0] model [3];

  always #5 clk = ~clk;

  twowire_trim_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull_o(sda_pull), .wr_stb_o(wr_stb), .wr_csr_o(wr_csr),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data), .wiper_o(wiper), .csr_o(csr)
  );

  always @(posedge clk) if (rst_n && wr_stb) begin
    nstb <= nstb + 1;
    last_csr <= wr_csr;
    last_idx <= wr_idx;
    last_data <= wr_data;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic bit_out(input logic b);
    tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) bit_out(b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
    tick(1); ack_early = sda_line;
    tick(2*Q - 2); ack_late = sda_line;
    tick(1); scl_m = 1'b0;
    tick(6); ack_after = sda_line;
    acked = !ack_late;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic [7:0] t;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
      tick(Q); t[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = !give_ack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
    d = t;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start(); send_byte(8'hAE, a); send_byte(p, a); bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] addr, output logic [7:0] d);
    logic a;
    bus_start(); send_byte(addr, a); read_byte(1'b0, d); bus_stop();
  endtask

  task automatic csr_wr(input logic [7:0] v);
    logic a;
    bus_start(); send_byte(8'hA4, a); send_byte(v, a); bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a, a2;
    logic [7:0] d, d2;
    int s0;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 reset state
    chk("R1 pull", {31'd0, sda_pull}, 32'd0);
    chk("R1 csr", {24'd0, csr}, 32'd0);
    chk("R1 wipers", {8'd0, wiper}, 32'h808080);
    for (int i = 0; i < 3; i++) model[i] = 8'h80;

    // R2 R3 full address sweep
    for (int i = 0; i < 256; i++) begin
      logic [7:0] ad;
      logic expa;
      ad = 8'(i);
      expa = (ad[7:4] == 4'b1010) && (ad[3:1] == 3'b111 || ad[3:1] == 3'b010);
      bus_start();
      send_byte(ad, a);
      chk($sformatf("R3 addr %02h ack", ad), {31'd0, a}, {31'd0, expa});
      if (!expa) begin
        send_byte(8'h00, a2);
        chk($sformatf("R2 addr %02h follow-on silent", ad), {31'd0, a2}, 32'd0);
      end else if (ad[0]) begin
        read_byte(1'b0, d);
      end
      bus_stop();
    end
    chk("R2 csr untouched", {24'd0, csr}, 32'd0);
    chk("R2 wipers untouched", {8'd0, wiper}, 32'h808080);

    // R7 latch clear: write accepted on the bus but not applied
    s0 = nstb;
    bus_start(); send_byte(8'hAE, a); send_byte(8'h01, a); send_byte(8'h33, a); bus_stop();
    chk("R7 data ack with latch clear", {31'd0, a}, 32'd1);
    chk("R7 wiper held with latch clear", {8'd0, wiper}, 32'h808080);
    chk("R7 no strobe with latch clear", nstb, s0);

    // R5 R4 control write and acknowledge timing
    s0 = nstb;
    bus_start(); send_byte(8'hA4, a); send_byte(8'h01, a);
    chk("R4 ack low early", {31'd0, ack_early}, 32'd0);
    chk("R4 ack low late", {31'd0, ack_late}, 32'd0);
    chk("R4 released after", {31'd0, ack_after}, 32'd1);
    send_byte(8'hFF, a2);
    bus_stop();
    chk("R5 csr loaded", {24'd0, csr}, 32'h01);
    chk("R5 one strobe", nstb, s0 + 1);
    chk("R5 strobe flags", {23'd0, last_csr, last_data}, {23'd0, 1'b1, 8'h01});
    chk("R5 third byte refused", {31'd0, a2}, 32'd0);

    // R6 R7 pointer and value sweep with latch set
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] v;
        logic [7:0] pb;
        v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'(p * 49 + 7);
        pb = {6'(k * 13), 2'(p)};
        s0 = nstb;
        bus_start(); send_byte(8'hAE, a); send_byte(pb, a); send_byte(v, a2); bus_stop();
        chk($sformatf("R6 ptr %0d ack", p), {31'd0, a}, {31'd0, p < 3});
        chk($sformatf("R7 ptr %0d data ack", p), {31'd0, a2}, {31'd0, p < 3});
        if (p < 3) begin
          model[p] = v;
          chk("R7 strobe", nstb, s0 + 1);
          chk("R7 strobe idx", {30'd0, last_idx}, 32'(p));
        end else begin
          chk("R6 no strobe on reserved pointer", nstb, s0);
        end
        chk("R7 wiper bank", {8'd0, wiper}, {8'd0, model[2], model[1], model[0]});
      end
    end
    for (int p = 0; p < 3; p++) begin
      set_ptr(8'(p));
      rd_reg(8'hAF, d);
      chk($sformatf("R8 readback wiper %0d", p), {24'd0, d}, {24'd0, model[p]});
    end

    // R10 fourth byte refused
    bus_start(); send_byte(8'hAE, a); send_byte(8'h00, a); send_byte(8'h11, a);
    send_byte(8'h22, a2); bus_stop();
    model[0] = 8'h11;
    chk("R10 fourth byte refused", {31'd0, a2}, 32'd0);
    chk("R10 wiper0", {24'd0, wiper[7:0]}, 32'h11);

    // R8 repeated read then release
    set_ptr(8'h02);
    bus_start(); send_byte(8'hAF, a);
    read_byte(1'b1, d); read_byte(1'b0, d2);
    chk("R8 first byte", {24'd0, d}, {24'd0, model[2]});
    chk("R8 repeated byte", {24'd0, d2}, {24'd0, model[2]});
    send_bits(8'h80, 1);
    chk("R8 silent after nack", {31'd0, sda_line}, 32'd1);
    bus_stop();
    rd_reg(8'hA5, d);
    chk("R8 control read", {24'd0, d}, 32'h01);

    // R9 STOP mid byte
    s0 = nstb;
    bus_start(); send_byte(8'hAE, a); send_byte(8'h01, a); send_bits(8'h99, 4); bus_stop();
    chk("R9 stop abort no write", {24'd0, wiper[15:8]}, {24'd0, model[1]});
    chk("R9 stop abort no strobe", nstb, s0);
    // R9 repeated START mid byte
    bus_start(); send_byte(8'hAE, a); send_byte(8'h02, a); send_bits(8'hC3, 5);
    bus_start(); send_byte(8'hAE, a); send_byte(8'h02, a); send_byte(8'h77, a2); bus_stop();
    model[2] = 8'h77;
    chk("R9 restart accepted", {31'd0, a2}, 32'd1);
    chk("R9 restart write", {8'd0, wiper}, {8'd0, model[2], model[1], model[0]});

    // R7 latch cleared again blocks writes
    csr_wr(8'h00);
    bus_start(); send_byte(8'hAE, a); send_byte(8'h00, a); send_byte(8'hEE, a); bus_stop();
    chk("R7 latch cleared blocks", {24'd0, wiper[7:0]}, {24'd0, model[0]});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule